// File: doc/BRIEF.md
# Single-Digit BCD Counter with Separate Up and Down Strobes

This block holds one decimal digit in 8421 code and moves it with two independent count strobes. A rising edge on the up strobe adds one. A rising edge on the down strobe takes one away. An edge only counts while the other strobe rests high. An active-high clear forces the digit to zero. An active-low load copies a 4-bit preset value into the digit. Both of these are level controls that win over any strobe activity.

Two outputs, carry and borrow, are active low and follow the shape of their own strobe. Carry goes low only while the digit shows nine and the up strobe is low. Borrow goes low only while the digit shows zero and the down strobe is low. Wiring carry to the up strobe of the next digit, and borrow to its down strobe, builds a multi-digit decimal counter with no glue logic between stages.

Every input is taken into one free-running system clock domain. Each strobe passes through a synchronizer of `SYNC_STAGES` flops, and its edges are found by comparing the synchronized level with the previous sample. Clear, load and preset are treated as synchronous to that clock.

Top module: `bcd_dual_strobe_digit`

## Requirements
- R1: After reset the digit reads 0, and carry_out_n and borrow_out_n are both high.
- R2: A rising edge of up_strobe while dn_strobe is high adds one on the third clock edge after the input change. A digit of 9 goes to 0.
- R3: A rising edge of dn_strobe while up_strobe is high takes one away, with the same latency as R2. A digit of 0 goes to 9.
- R4: A rising edge of up_strobe while dn_strobe is low, a rising edge of dn_strobe while up_strobe is low, and rising edges on both strobes in the same cycle all leave the digit unchanged.
- R5: While clr is high, the digit is 0 on the next clock edge, whatever load_n and the strobes do.
- R6: While clr is low and load_n is low, the digit takes the value of preset on the next clock edge, and strobe edges have no effect.
- R7: carry_out_n is low exactly when the digit equals 9 and the synchronized up strobe is low. Otherwise it is high.
- R8: borrow_out_n is low exactly when the digit equals 0 and the synchronized down strobe is low. Otherwise it is high.
- R9: If a strobe is held low while clr or load_n is active and stays low after release, its next rising edge counts normally.
- R10: A preset value from 10 to 15 counts up to (value+1) mod 16 and down to value-1, with no carry or borrow. Once the digit is in 0..9 and neither clr nor load_n is active, it stays in 0..9.
- R11: With carry_out_n wired to the next digit's up_strobe and borrow_out_n wired to its dn_strobe, two digits count as a decimal pair 00..99. They wrap 99 to 00 going up and 00 to 99 going down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_strobe | input | 1 | Count-up strobe, rising edge counts |
| dn_strobe | input | 1 | Count-down strobe, rising edge counts |
| clr | input | 1 | Clear to zero, active high, highest priority |
| load_n | input | 1 | Load preset, active low |
| preset | input | 4 | Value copied in by load |
| digit | output | 4 | Current BCD digit |
| carry_out_n | output | 1 | Carry, active low, follows up strobe at 9 |
| borrow_out_n | output | 1 | Borrow, active low, follows down strobe at 0 |

## Verification
The properties assume that clr, load_n and preset change only in step with the system clock. They also assume that each strobe level lasts long enough for the synchronizer to pass it, so that a detected rising edge always belongs to a single strobe transition. The bench drives every input on the falling clock edge and holds each strobe, clear and load level for eight clock cycles, which is more than the synchronizer and edge-detect latency of both chained digits. Loads and clears are applied with both strobes high, or with a strobe parked low that does not bring a chained carry or borrow out of its idle level outside the override window.

// File: rtl/bcd_dual_pkg.sv
package bcd_dual_pkg;

    localparam int DIGIT_W   = 4;
    localparam int DIGIT_TOP = 9;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef struct packed {
        digit_t value;
        logic   up_prev;
        logic   dn_prev;
    } digit_state_t;

    // Up step: 9 wraps to 0, out-of-range codes roll modulo 16.
    function automatic digit_t digit_step_up(input digit_t v);
        digit_t r;
        if (v == digit_t'(DIGIT_TOP)) r = '0;
        else                          r = v + digit_t'(1);
        return r;
    endfunction

    // Down step: 0 wraps to 9, any other code decrements.
    function automatic digit_t digit_step_down(input digit_t v);
        digit_t r;
        if (v == '0) r = digit_t'(DIGIT_TOP);
        else         r = v - digit_t'(1);
        return r;
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o
);
    localparam int N = (STAGES < 2) ? 2 : STAGES;

    logic [N-1:0] pipe_d;
    logic [N-1:0] pipe_q;

    generate
        if (N == 2) begin : g_two
            always_comb pipe_d = {pipe_q[0], async_i};
        end else begin : g_many
            always_comb pipe_d = {pipe_q[N-2:0], async_i};
        end
    endgenerate

    // Idle strobe level is high, so reset to ones to avoid a false edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign level_o = pipe_q[N-1];
endmodule

// File: rtl/bcd_digit_core.sv
module bcd_digit_core
    import bcd_dual_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   up_lvl,
    input  logic   dn_lvl,
    input  logic   clr,
    input  logic   load_n,
    input  digit_t preset,
    output digit_t value,
    output logic   carry_n,
    output logic   borrow_n
);
    digit_state_t st_d;
    digit_state_t st_q;
    logic         up_rise;
    logic         dn_rise;

    always_comb begin
        st_d         = st_q;
        st_d.up_prev = up_lvl;
        st_d.dn_prev = dn_lvl;
        up_rise      = up_lvl & ~st_q.up_prev;
        dn_rise      = dn_lvl & ~st_q.dn_prev;

        if (clr) begin
            st_d.value = '0;
        end else if (!load_n) begin
            st_d.value = preset;
        end else if (up_rise && !dn_rise && dn_lvl) begin
            st_d.value = digit_step_up(st_q.value);
        end else if (dn_rise && !up_rise && up_lvl) begin
            st_d.value = digit_step_down(st_q.value);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.value   <= '0;
            st_q.up_prev <= 1'b1;
            st_q.dn_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign value    = st_q.value;
    assign carry_n  = ~((st_q.value == digit_t'(DIGIT_TOP)) & ~up_lvl);
    assign borrow_n = ~((st_q.value == '0) & ~dn_lvl);
endmodule

// File: rtl/bcd_dual_strobe_digit.sv
module bcd_dual_strobe_digit #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       up_strobe,
    input  logic       dn_strobe,
    input  logic       clr,
    input  logic       load_n,
    input  logic [3:0] preset,
    output logic [3:0] digit,
    output logic       carry_out_n,
    output logic       borrow_out_n
);
    logic up_lvl;
    logic dn_lvl;

    strobe_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
        .clk(clk), .rst_n(rst_n), .async_i(up_strobe), .level_o(up_lvl)
    );

    strobe_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
        .clk(clk), .rst_n(rst_n), .async_i(dn_strobe), .level_o(dn_lvl)
    );

    bcd_digit_core u_core (
        .clk(clk), .rst_n(rst_n),
        .up_lvl(up_lvl), .dn_lvl(dn_lvl),
        .clr(clr), .load_n(load_n), .preset(preset),
        .value(digit), .carry_n(carry_out_n), .borrow_n(borrow_out_n)
    );
endmodule

// File: rtl/bcd_digit_checks.sv
module bcd_digit_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       clr,
    input logic       load_n,
    input logic [3:0] preset,
    input logic [3:0] digit,
    input logic       carry_out_n,
    input logic       borrow_out_n,
    input logic       up_lvl,
    input logic       dn_lvl
);
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (digit == 4'd0));

    a_r6_load_preset: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load_n) |=> (digit == $past(preset)));

    a_r2_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load_n && $rose(up_lvl) && dn_lvl && !$rose(dn_lvl) && digit == 4'd9)
        |=> (digit == 4'd0));

    a_r3_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load_n && $rose(dn_lvl) && up_lvl && !$rose(up_lvl) && digit == 4'd0)
        |=> (digit == 4'd9));

    a_r4_both_edges_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load_n && $rose(up_lvl) && $rose(dn_lvl)) |=> $stable(digit));

    a_r7_carry_at_nine: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_out_n |-> (digit == 4'd9));

    a_r8_borrow_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_out_n |-> (digit == 4'd0));

    a_r10_stays_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load_n && digit <= 4'd9) |=> (digit <= 4'd9));
endmodule

bind bcd_dual_strobe_digit bcd_digit_checks u_checks (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .preset(preset),
    .digit(digit), .carry_out_n(carry_out_n), .borrow_out_n(borrow_out_n),
    .up_lvl(up_lvl), .dn_lvl(dn_lvl)
);

// File: tb/bcd_dual_strobe_digit_test.sv
module bcd_dual_strobe_digit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       up = 1'b1;
    logic       dn = 1'b1;
    logic       clr = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] pre_lo = 4'd0;
    logic [3:0] pre_hi = 4'd0;
    logic [3:0] lo_digit, hi_digit;
    logic       lo_carry_n, lo_borrow_n, hi_carry_n, hi_borrow_n;

    int errors = 0;
    int checks = 0;
    int m_lo = 0;
    int m_hi = 0;
    bit done = 1'b0;

    localparam int HOLD = 8;

    always #2 clk = ~clk;

    bcd_dual_strobe_digit uut (
        .clk(clk), .rst_n(rst_n), .up_strobe(up), .dn_strobe(dn),
        .clr(clr), .load_n(load_n), .preset(pre_lo),
        .digit(lo_digit), .carry_out_n(lo_carry_n), .borrow_out_n(lo_borrow_n)
    );

    bcd_dual_strobe_digit uut_hi (
        .clk(clk), .rst_n(rst_n), .up_strobe(lo_carry_n), .dn_strobe(lo_borrow_n),
        .clr(clr), .load_n(load_n), .preset(pre_hi),
        .digit(hi_digit), .carry_out_n(hi_carry_n), .borrow_out_n(hi_borrow_n)
    );

    function automatic int inc_d(input int v);
        return (v == 9) ? 0 : (v + 1) % 16;
    endfunction

    function automatic int dec_d(input int v);
        return (v == 0) ? 9 : v - 1;
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic check_counts(input string req);
        check(req, int'(lo_digit), m_lo, "low digit");
        check(req, int'(hi_digit), m_hi, "high digit");
    endtask

    task automatic up_pulse(input string req);
        @(negedge clk) up = 1'b0;
        settle();
        check("R7", int'(lo_carry_n), (m_lo == 9) ? 0 : 1, "low carry while up low");
        check("R11", int'(hi_carry_n), (m_lo == 9 && m_hi == 9) ? 0 : 1, "final carry");
        @(negedge clk) up = 1'b1;
        if (!clr && load_n) begin
            if (m_lo == 9) m_hi = inc_d(m_hi);
            m_lo = inc_d(m_lo);
        end
        settle();
        check_counts(req);
    endtask

    task automatic dn_pulse(input string req);
        @(negedge clk) dn = 1'b0;
        settle();
        check("R8", int'(lo_borrow_n), (m_lo == 0) ? 0 : 1, "low borrow while dn low");
        check("R11", int'(hi_borrow_n), (m_lo == 0 && m_hi == 0) ? 0 : 1, "final borrow");
        @(negedge clk) dn = 1'b1;
        if (!clr && load_n) begin
            if (m_lo == 0) m_hi = dec_d(m_hi);
            m_lo = dec_d(m_lo);
        end
        settle();
        check_counts(req);
    endtask

    task automatic do_load(input int lo, input int hi);
        @(negedge clk) begin pre_lo = 4'(lo); pre_hi = 4'(hi); load_n = 1'b0; end
        settle();
        @(negedge clk) load_n = 1'b1;
        m_lo = lo; m_hi = hi;
        settle();
        check_counts("R6");
    endtask

    task automatic t_reset();
        check_counts("R1");
        check("R1", int'(lo_carry_n), 1, "carry after reset");
        check("R1", int'(lo_borrow_n), 1, "borrow after reset");
    endtask

    task automatic t_count_up();
        for (int i = 0; i < 12; i++) up_pulse("R2");
    endtask

    task automatic t_count_down();
        for (int i = 0; i < 15; i++) dn_pulse("R3");
    endtask

    task automatic t_chain_wrap();
        do_load(8, 9);
        for (int i = 0; i < 3; i++) up_pulse("R11");
        for (int i = 0; i < 2; i++) dn_pulse("R11");
    endtask

    task automatic t_clear_load();
        @(negedge clk) begin pre_lo = 4'd7; pre_hi = 4'd7; clr = 1'b1; load_n = 1'b0; end
        m_lo = 0; m_hi = 0;
        settle();
        check_counts("R5");
        up_pulse("R5");
        @(negedge clk) clr = 1'b0;
        m_lo = 7; m_hi = 7;
        settle();
        check_counts("R6");
        up_pulse("R6");
        @(negedge clk) load_n = 1'b1;
        settle();
        check_counts("R6");
        up_pulse("R2");
    endtask

    task automatic t_ignored();
        do_load(5, 3);
        @(negedge clk) dn = 1'b0;
        settle();
        @(negedge clk) up = 1'b0;
        settle();
        @(negedge clk) up = 1'b1;
        settle();
        check_counts("R4");
        @(negedge clk) up = 1'b0;
        settle();
        @(negedge clk) dn = 1'b1;
        settle();
        check_counts("R4");
        @(negedge clk) up = 1'b1;
        m_lo = 6;
        settle();
        check_counts("R4");
        @(negedge clk) begin up = 1'b0; dn = 1'b0; end
        settle();
        @(negedge clk) begin up = 1'b1; dn = 1'b1; end
        settle();
        check_counts("R4");
    endtask

    task automatic t_release_low();
        @(negedge clk) up = 1'b0;
        settle();
        @(negedge clk) clr = 1'b1;
        settle();
        @(negedge clk) clr = 1'b0;
        m_lo = 0; m_hi = 0;
        settle();
        check_counts("R9");
        @(negedge clk) up = 1'b1;
        m_lo = 1;
        settle();
        check_counts("R9");
        do_load(3, 5);
        @(negedge clk) dn = 1'b0;
        settle();
        @(negedge clk) begin pre_lo = 4'd0; pre_hi = 4'd5; load_n = 1'b0; end
        settle();
        @(negedge clk) load_n = 1'b1;
        m_lo = 0; m_hi = 5;
        settle();
        check_counts("R9");
        @(negedge clk) dn = 1'b1;
        m_lo = 9; m_hi = 4;
        settle();
        check_counts("R9");
    endtask

    task automatic t_illegal();
        do_load(12, 0);
        for (int i = 0; i < 4; i++) up_pulse("R10");
        do_load(10, 3);
        dn_pulse("R10");
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_count_up();
        t_count_down();
        t_chain_wrap();
        t_clear_load();
        t_ignored();
        t_release_low();
        t_illegal();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule